// File: doc/BRIEF.md
# Tri-State PWM Channel with Coded Prescaler

This block produces one pulse-width-modulated pin. A prescaler divides the system clock by a ratio picked from a fixed, non-uniform set; every prescaler wrap advances a tick counter. The counter runs from 0 up to a programmed end value and then returns to 0. Two compare positions, the "on" point and the "off" point, move the pin between an on drive state and an off drive state. Each drive state can drive the pin low, drive it high, or release it to high impedance. The block presents the pin as a data bit and an output-enable bit.

Software programs the block through a single write port with three addresses: an enable word, a compare word that stages the on and off points, and a timing word that stages the period, the prescaler code and both drive states. Software writes the compare word first and the timing word second. Writing the timing word arms a commit. The commit copies both staged words into the working registers. It happens at once while the channel is disabled. While the channel runs, it waits for the end of the current cycle, so a running cycle is never cut short.

Top module: `tristate_pwm`

## Requirements
- R1: After reset the channel is disabled, `chanEnabled` reads 0 and `pinOe` is 0.
- R2: The prescaler code in timing-word bits [CNT_W+6:CNT_W+4] selects the clock divide ratio, and one tick lasts that many clocks. Codes 0 to 7 select 1, 2, 4, 8, 16, 64, 256 and 1024.
- R3: The period field in timing-word bits [CNT_W-1:0] holds N, and the tick counter counts 0..N and then wraps to 0. One cycle therefore lasts N+1 ticks.
- R4: A drive state is a 2-bit code. 0 drives the pin low (`pinOe`=1, `pinOut`=0). 1 drives it high (`pinOe`=1, `pinOut`=1). 2 and 3 release it (`pinOe`=0, `pinOut`=0). The on state sits in timing-word bits [CNT_W+1:CNT_W] and the off state in bits [CNT_W+3:CNT_W+2].
- R5: The compare word holds the on point in bits [CNT_W-1:0] and the off point in bits [2*CNT_W-1:CNT_W]. In a cycle where the counter equals the off point, the pin shows the off state. Otherwise, where it equals the on point, the pin shows the on state. Otherwise the pin keeps its last state. After enable, the pin starts in the off state. When both points are equal, the off state wins.
- R6: A compare-word write on its own does not change the output while the channel runs.
- R7: A timing-word write commits both staged words. While the channel runs, the commit waits until the counter wraps from N to 0. While the channel is disabled, it completes one clock after the write.
- R8: While the channel is disabled, `pinOe` is 0 and the prescaler and counter stay at 0. Enabling the channel starts the cycle at tick 0 with a fresh prescaler count.
- R9: Address 0 sets the enable from data bit 0. Address 1 writes the compare word and address 2 writes the timing word. `chanEnabled` shows the enable one clock after the write.
- R10: A duty of D percent comes from on point 0 and off point T*D/100, where T = N+1 ticks. It gives an on state that lasts exactly T*D/100 ticks in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 enable, 1 compare, 2 timing |
| wrData | input | 2*CNT_W | Write data |
| chanEnabled | output | 1 | Enable read-back |
| pinOut | output | 1 | Pin data |
| pinOe | output | 1 | Pin output-enable |

## Verification
The assertions assume that writes arrive only through the strobe and that the working period changes only at a wrap or while the channel is disabled. They also assume that the counter never passes the working period. The bench keeps to the write order the block expects: compare word, then timing word. It makes each write a single-clock strobe, and it changes configuration mostly while the channel is disabled. Running-channel updates are made with a compare write, or with a timing write followed by a wait for the boundary. A behavioural model compares the outputs on every clock. Directed measurements of on-run lengths check the divide ratios and the duty rule.

// File: rtl/tristate_pwm_pkg.sv
package tristate_pwm_pkg;

  localparam int PRE_W = 10;

  typedef enum logic [1:0] {
    ADDR_ENABLE  = 2'd0,
    ADDR_COMPARE = 2'd1,
    ADDR_TIMING  = 2'd2
  } regAddr_e;

  typedef struct packed {
    logic tick;
    logic wrap;
    logic commit;
    logic clear;
    logic wrCompare;
    logic wrTiming;
  } strobes_t;

  // divide ratio minus one for each prescaler code
  function automatic logic [PRE_W-1:0] divMinusOne(input logic [2:0] code);
    logic [PRE_W-1:0] r;
    case (code)
      3'd5:    r = PRE_W'(63);
      3'd6:    r = PRE_W'(255);
      3'd7:    r = PRE_W'(1023);
      default: r = PRE_W'((1 << code) - 1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tristate_pwm_ctrl.sv
module tristate_pwm_ctrl
  import tristate_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       wrBit0,
  input  logic [2:0] workCode,
  input  logic       atEnd,
  output logic       enQ,
  output strobes_t   strb
);

  logic             pendQ;
  logic [PRE_W-1:0] preCnt;

  always_comb begin
    strb.wrCompare = wrEn && (wrAddr == ADDR_COMPARE);
    strb.wrTiming  = wrEn && (wrAddr == ADDR_TIMING);
    strb.clear     = !enQ;
    strb.tick      = enQ && (preCnt == divMinusOne(workCode));
    strb.wrap      = strb.tick && atEnd;
    strb.commit    = pendQ && (!enQ || strb.wrap);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      pendQ  <= 1'b0;
      preCnt <= '0;
    end else begin
      if (wrEn && (wrAddr == ADDR_ENABLE)) enQ <= wrBit0;
      if (strb.wrTiming)    pendQ <= 1'b1;
      else if (strb.commit) pendQ <= 1'b0;
      if (strb.clear || strb.tick) preCnt <= '0;
      else                         preCnt <= preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/tristate_pwm_dp.sv
module tristate_pwm_dp
  import tristate_pwm_pkg::*;
#(
  parameter  int CNT_W  = 16,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [2:0]        workCode,
  output logic              atEnd,
  output logic [CNT_W-1:0]  tickCnt,
  output logic [CNT_W-1:0]  workPeriod,
  output logic              pinOut,
  output logic              pinOe
);

  localparam int ON_ST_LSB  = CNT_W;
  localparam int OFF_ST_LSB = CNT_W + 2;
  localparam int CODE_LSB   = CNT_W + 4;

  logic [CNT_W-1:0] stOn, stOff, stPeriod, workOn, workOff;
  logic [1:0]       stOnDrv, stOffDrv, workOnDrv, workOffDrv, curDrv;
  logic [2:0]       stCode;
  logic             phaseQ, curOn;

  always_comb begin
    atEnd = (tickCnt == workPeriod);
    if (tickCnt == workOff)     curOn = 1'b0;
    else if (tickCnt == workOn) curOn = 1'b1;
    else                        curOn = phaseQ;
    curDrv = curOn ? workOnDrv : workOffDrv;
    pinOe  = !strb.clear && !curDrv[1];
    pinOut = pinOe && curDrv[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stOn <= '0; stOff <= '0; stPeriod <= '0;
      stOnDrv <= 2'd2; stOffDrv <= 2'd2; stCode <= '0;
      workOn <= '0; workOff <= '0; workPeriod <= '0;
      workOnDrv <= 2'd2; workOffDrv <= 2'd2; workCode <= '0;
      tickCnt <= '0; phaseQ <= 1'b0;
    end else begin
      if (strb.wrCompare) begin
        stOn  <= wrData[CNT_W-1:0];
        stOff <= wrData[DATA_W-1:CNT_W];
      end
      if (strb.wrTiming) begin
        stPeriod <= wrData[CNT_W-1:0];
        stOnDrv  <= wrData[ON_ST_LSB+1:ON_ST_LSB];
        stOffDrv <= wrData[OFF_ST_LSB+1:OFF_ST_LSB];
        stCode   <= wrData[CODE_LSB+2:CODE_LSB];
      end
      if (strb.commit) begin
        workOn <= stOn; workOff <= stOff; workPeriod <= stPeriod;
        workOnDrv <= stOnDrv; workOffDrv <= stOffDrv; workCode <= stCode;
      end
      if (strb.clear) begin
        tickCnt <= '0;
        phaseQ  <= 1'b0;
      end else begin
        phaseQ <= curOn;
        if (strb.tick) tickCnt <= strb.wrap ? '0 : tickCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tristate_pwm.sv
module tristate_pwm
  import tristate_pwm_pkg::*;
#(
  parameter  int CNT_W  = 16,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              chanEnabled,
  output logic              pinOut,
  output logic              pinOe
);

  strobes_t         strb;
  logic [2:0]       workCode;
  logic             atEnd;
  logic [CNT_W-1:0] tickCnt, workPeriod;

  tristate_pwm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]),
    .workCode(workCode), .atEnd(atEnd), .enQ(chanEnabled), .strb(strb)
  );

  tristate_pwm_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .workCode(workCode), .atEnd(atEnd), .tickCnt(tickCnt),
    .workPeriod(workPeriod), .pinOut(pinOut), .pinOe(pinOe)
  );

endmodule

// File: rtl/tristate_pwm_chk.sv
module tristate_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enQ,
  input logic             tick,
  input logic             wrap,
  input logic [CNT_W-1:0] tickCnt,
  input logic [CNT_W-1:0] workPeriod,
  input logic             pinOe
);

  p_released_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !pinOe);

  p_held_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> (tickCnt == '0));

  p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= workPeriod);

  p_count_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !tick) |=> $stable(tickCnt));

  p_commit_at_boundary_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !wrap) |=> $stable(workPeriod));

endmodule

bind tristate_pwm tristate_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .enQ(chanEnabled), .tick(strb.tick), .wrap(strb.wrap),
  .tickCnt(tickCnt), .workPeriod(workPeriod), .pinOe(pinOe)
);

// File: tb/tristate_pwm_tb.sv
module tristate_pwm_tb_top;

  localparam int CNT_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrAddr = 2'd0;
  logic [2*CNT_W-1:0] wrData = '0;
  logic              chanEnabled, pinOut, pinOe;

  int  nTests = 0;
  int  nFails = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  tristate_pwm #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chanEnabled(chanEnabled), .pinOut(pinOut), .pinOe(pinOe)
  );

  // ---------------- behavioural reference model ----------------
  int mEn, mPend, sOn, sOff, sPer, sCode, sOnD, sOffD;
  int wOn, wOff, wPer, wCode, wOnD, wOffD, mPre, mCnt, mPh;

  function automatic int ratioOf(input int code);
    int t[8] = '{1, 2, 4, 8, 16, 64, 256, 1024};
    return t[code];
  endfunction

  function automatic int modelOn();
    if (mCnt == wOff) return 0;
    if (mCnt == wOn)  return 1;
    return mPh;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mPend = 0; sOn = 0; sOff = 0; sPer = 0; sCode = 0; sOnD = 2; sOffD = 2;
      wOn = 0; wOff = 0; wPer = 0; wCode = 0; wOnD = 2; wOffD = 2;
      mPre = 0; mCnt = 0; mPh = 0;
    end else begin
      int tick, wrp, com, on;
      tick = (mEn != 0) && (mPre == ratioOf(wCode) - 1);
      wrp  = tick && (mCnt == wPer);
      com  = (mPend != 0) && (mEn == 0 || wrp);
      on   = modelOn();
      if (mEn == 0) begin mPre = 0; mCnt = 0; mPh = 0; end
      else begin
        mPh = on;
        if (tick) begin mPre = 0; mCnt = wrp ? 0 : mCnt + 1; end
        else mPre = mPre + 1;
      end
      if (com) begin
        wOn = sOn; wOff = sOff; wPer = sPer; wCode = sCode; wOnD = sOnD; wOffD = sOffD;
        mPend = 0;
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mEn = wrData[0];
          2'd1: begin sOn = wrData[15:0]; sOff = wrData[31:16]; end
          2'd2: begin
            sPer = wrData[15:0]; sOnD = wrData[17:16]; sOffD = wrData[19:18];
            sCode = wrData[22:20]; mPend = 1;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R4, R5, R8, R9)
  always @(negedge clk) begin
    if (rstN && !done) begin
      int eOe, eOut, d;
      if (mEn == 0) begin eOe = 0; eOut = 0; end
      else begin
        d = (modelOn() != 0) ? wOnD : wOffD;
        eOe = (d < 2); eOut = (d == 1);
      end
      check(pinOe == eOe, (mEn == 0) ? "R8 oe" : "R4 R5 oe", pinOe, eOe);
      check(pinOut == eOut, "R4 R5 data", pinOut, eOut);
      check(chanEnabled == mEn, "R9 readback", chanEnabled, mEn);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [31:0] cmpWord(input int on, input int off);
    return 32'(on) | (32'(off) << 16);
  endfunction

  function automatic logic [31:0] timWord(input int per, input int code, input int onD, input int offD);
    return 32'(per) | (32'(onD) << 16) | (32'(offD) << 18) | (32'(code) << 20);
  endfunction

  task automatic measureHigh(output int n);
    n = 0;
    do @(negedge clk); while (pinOut);
    do @(negedge clk); while (!pinOut);
    while (pinOut) begin n++; @(negedge clk); end
  endtask

  task automatic countCycles(input int len, output int hi, output int oeLow);
    hi = 0; oeLow = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pinOut) hi++;
      if (!pinOe) oeLow++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int n, hi, ol;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(chanEnabled == 1'b0, "R1 enable", chanEnabled, 0);
    check(pinOe == 1'b0, "R1 oe", pinOe, 0);

    // R2: on state for one tick of a two-tick cycle lasts one prescaler ratio
    for (int code = 0; code < 8; code++) begin
      wr(2'd0, 32'd0);
      wr(2'd1, cmpWord(0, 1));
      wr(2'd2, timWord(1, code, 1, 0));
      wr(2'd0, 32'd1);
      check(chanEnabled == 1'b1, "R9 enable set", chanEnabled, 1);
      measureHigh(n);
      check(n == ratioOf(code), "R2 divide ratio", n, ratioOf(code));
    end

    // R10 / R3: 100-tick cycle at 30 percent
    wr(2'd0, 32'd0);
    wr(2'd1, cmpWord(0, 100 * 30 / 100));
    wr(2'd2, timWord(99, 0, 1, 0));
    wr(2'd0, 32'd1);
    measureHigh(n);
    check(n == 30, "R10 duty 30", n, 30);
    countCycles(200, hi, ol);
    check(hi == 60, "R3 high per 200 clocks", hi, 60);

    // R6: compare write alone has no effect while running
    wr(2'd1, cmpWord(0, 50));
    repeat (250) @(negedge clk);
    measureHigh(n);
    check(n == 30, "R6 staged compare ignored", n, 30);

    // R7: timing write commits at the boundary
    wr(2'd2, timWord(99, 0, 1, 0));
    measureHigh(n);
    check(n == 50, "R7 commit at boundary", n, 50);

    // R10: 40 ticks, ratio 2, 75 percent
    wr(2'd0, 32'd0);
    check(chanEnabled == 1'b0, "R9 enable clear", chanEnabled, 0);
    wr(2'd1, cmpWord(0, 40 * 75 / 100));
    wr(2'd2, timWord(39, 1, 1, 0));
    wr(2'd0, 32'd1);
    measureHigh(n);
    check(n == 60, "R10 duty 75", n, 60);

    // R5: equal points, off state wins
    wr(2'd0, 32'd0);
    wr(2'd1, cmpWord(3, 3));
    wr(2'd2, timWord(7, 0, 1, 0));
    wr(2'd0, 32'd1);
    countCycles(40, hi, ol);
    check(hi == 0, "R5 off wins", hi, 0);

    // R4: on state released, off state drives low
    wr(2'd0, 32'd0);
    wr(2'd1, cmpWord(0, 4));
    wr(2'd2, timWord(7, 0, 2, 0));
    wr(2'd0, 32'd1);
    repeat (3) @(negedge clk);
    countCycles(32, hi, ol);
    check(ol == 16, "R4 hi-z on state", ol, 16);
    check(hi == 0, "R4 hi-z data", hi, 0);

    // R4: off state drives high, on state drives low
    wr(2'd0, 32'd0);
    wr(2'd2, timWord(7, 0, 0, 1));
    wr(2'd0, 32'd1);
    repeat (3) @(negedge clk);
    countCycles(32, hi, ol);
    check(hi == 16, "R4 drive high off", hi, 16);
    check(ol == 0, "R4 always driven", ol, 0);

    // R8: disabled releases the pin
    wr(2'd0, 32'd0);
    countCycles(20, hi, ol);
    check(ol == 20, "R8 released while off", ol, 20);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule